// File: doc/BRIEF.md
# Indirect Host Register Port

This block is a byte-wide host port with eight external register locations. It gives a host indirect access to a 20-bit-wide internal channel address space. The host first loads a control register. That register holds the auto-increment flag, the broadcast flag, a 4-bit broadcast instruction and the top two internal address bits. The host then loads the low eight address bits into an address register. The 20-bit word is moved through three byte-wide data registers.

The low data register is the trigger. Writing it commits the word in one internal write strobe, using the bytes staged earlier in the two upper data registers. Reading it fetches the word and latches the upper bits, so that the two upper data registers then read back one coherent word. With auto-increment set, each trigger access advances the low address byte, which makes block loads efficient.

Several devices can share the bus. Each device has a 2-bit identifier. While broadcast is set, an access is accepted only by the devices that the instruction selects. Read-back of the address and data registers is suppressed, so that several devices never drive the bus together. The channel memory is a simple internal stub.

Top module: `hostport_indirect`

## Requirements
- R1: Register select `bus_addr` 7 is the control register. Its bit 7 is auto-increment, bit 6 is broadcast, bits 5:2 are the instruction and bits 1:0 are internal address bits 9:8. A read returns the last byte written.
- R2: `bus_addr` 6 holds internal address bits 7:0. It is readable while broadcast is clear.
- R3: Writes to `bus_addr` 2 (bits 3:0 are word bits 19:16, bits 7:4 are ignored) and to `bus_addr` 1 (word bits 15:8) only stage bytes. A write to `bus_addr` 0 raises `mem_we` for exactly that cycle. The internal address is {control[1:0], address byte} and the data is {staged 19:16, staged 15:8, written byte}.
- R4: A read of `bus_addr` 0 raises `mem_re`, returns word bits 7:0 and latches the upper 12 bits. Later reads of `bus_addr` 1 and 2 return bits 15:8 and {4'b0, bits 19:16} from that latch, even if the memory has changed since.
- R5: When auto-increment is set, every accepted `bus_addr` 0 access adds one to the address byte. When it is clear, the address byte is unchanged.
- R6: The address byte wraps from 255 to 0 on increment, and address bits 9:8 do not change.
- R7: While broadcast is set, reads of `bus_addr` 6, 2, 1 and 0 do not drive the bus (`rd_valid` stays 0) and raise no `mem_re`.
- R8: Broadcast instruction decode against `chip_id` works as follows. 1000 selects ID bit 0 = 0. 1001 selects ID bit 0 = 1. 1100, 1101, 1110 and 1111 select ID = 00, 01, 10 and 11. Every other code selects all chips. A chip that is not selected ignores every access except one to `bus_addr` 7.
- R9: While broadcast is clear, every access is accepted whatever `chip_id` is.
- R10: An accepted, driven read shows `rd_valid` = 1 with `rd_data` one cycle after the access cycle. After reset all registers, `rd_valid` and `rd_data` are 0.
- R11: `bus_addr` 5, 4 and 3 are plain byte registers that read back what was written.
- R12: A write to `bus_addr` 7 is accepted by every chip, even while broadcast is set and the chip is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_id | input | 2 | Identifier of this device on the shared bus |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | External register select |
| bus_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | This device drives `rd_data` this cycle |
| rd_data | output | 8 | Read byte |
| mem_we | output | 1 | Internal write strobe |
| mem_re | output | 1 | Internal read strobe |
| mem_addr | output | 10 | Internal address |
| mem_wdata | output | 20 | Internal write word |

## Verification
The bench sweeps all sixteen instruction codes against all four identifiers while broadcast is set. A wrong decode shows up as a missing or stray write in a word that is read back later with broadcast clear. It also shows up as a read that is driven when it should be suppressed. The bench crosses the 255-to-0 boundary with auto-increment on; a design that carried into bits 9:8 or stopped at 255 lands words at the wrong addresses. It overwrites a word between reading the low byte and reading the upper bytes; a design that fetched live instead of latching returns a torn word. It also writes the control register on a chip that is not selected; a design that gated that write could never leave broadcast.

// File: rtl/hostport_indirect.sv
module hostport_indirect #(
  parameter int BUS_W  = 8,
  parameter int WORD_W = 20,
  parameter int HI_AW  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                chip_id,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [2:0]                bus_addr,
  input  logic [BUS_W-1:0]          bus_wdata,
  output logic                      rd_valid,
  output logic [BUS_W-1:0]          rd_data,
  output logic                      mem_we,
  output logic                      mem_re,
  output logic [BUS_W+HI_AW-1:0]    mem_addr,
  output logic [WORD_W-1:0]         mem_wdata
);
  localparam int AW     = BUS_W + HI_AW;
  localparam int DEPTH  = 1 << AW;
  localparam int UP_W   = WORD_W - BUS_W;
  localparam int TOP_W  = WORD_W - 2 * BUS_W;

  localparam logic [2:0] A_CTL = 3'd7;
  localparam logic [2:0] A_PTR = 3'd6;
  localparam logic [2:0] A_SF2 = 3'd5;
  localparam logic [2:0] A_SF1 = 3'd4;
  localparam logic [2:0] A_SF0 = 3'd3;
  localparam logic [2:0] A_D2  = 3'd2;
  localparam logic [2:0] A_D1  = 3'd1;
  localparam logic [2:0] A_D0  = 3'd0;

  logic [BUS_W-1:0]  acr, car, sf2_q, sf1_q, sf0_q, stage1;
  logic [TOP_W-1:0]  stage2;
  logic [UP_W-1:0]   hold;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] mem_word;
  logic              id_hit, accept, do_wr, do_rd, quiet_rd, trig;
  logic [BUS_W-1:0]  rd_mux;

  wire       bcast = acr[6];
  wire       autoinc = acr[7];
  wire [3:0] instr = acr[5:2];

  always_comb begin
    case (instr)
      4'b1000: id_hit = ~chip_id[0];
      4'b1001: id_hit = chip_id[0];
      4'b1100, 4'b1101, 4'b1110, 4'b1111: id_hit = (chip_id == instr[1:0]);
      default: id_hit = 1'b1;
    endcase
  end

  assign accept   = bus_sel & ((bus_addr == A_CTL) | ~bcast | id_hit);
  assign quiet_rd = bcast & ((bus_addr == A_PTR) | (bus_addr <= A_D2));
  assign do_wr    = accept & bus_wr;
  assign do_rd    = accept & ~bus_wr & ~quiet_rd;
  assign mem_we   = do_wr & (bus_addr == A_D0);
  assign mem_re   = do_rd & (bus_addr == A_D0);
  assign trig     = mem_we | mem_re;

  assign mem_addr  = {acr[HI_AW-1:0], car};
  assign mem_wdata = {stage2, stage1, bus_wdata};
  assign mem_word  = mem[mem_addr];

  always_ff @(posedge clk)
    if (mem_we) mem[mem_addr] <= mem_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acr    <= '0;
      car    <= '0;
      sf2_q  <= '0;
      sf1_q  <= '0;
      sf0_q  <= '0;
      stage1 <= '0;
      stage2 <= '0;
      hold   <= '0;
    end else begin
      if (do_wr) begin
        case (bus_addr)
          A_CTL: acr    <= bus_wdata;
          A_PTR: car    <= bus_wdata;
          A_SF2: sf2_q  <= bus_wdata;
          A_SF1: sf1_q  <= bus_wdata;
          A_SF0: sf0_q  <= bus_wdata;
          A_D2:  stage2 <= bus_wdata[TOP_W-1:0];
          A_D1:  stage1 <= bus_wdata;
          default: ;
        endcase
      end
      if (mem_re) hold <= mem_word[WORD_W-1:BUS_W];
      if (trig && autoinc) car <= car + 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   rd_mux = acr;
      A_PTR:   rd_mux = car;
      A_SF2:   rd_mux = sf2_q;
      A_SF1:   rd_mux = sf1_q;
      A_SF0:   rd_mux = sf0_q;
      A_D2:    rd_mux = {{(BUS_W-TOP_W){1'b0}}, hold[UP_W-1:BUS_W]};
      A_D1:    rd_mux = hold[BUS_W-1:0];
      default: rd_mux = mem_word[BUS_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/hostport_indirect_chk.sv
module hostport_indirect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chip_id,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic [7:0] acr,
  input logic [7:0] car,
  input logic       mem_we,
  input logic       mem_re,
  input logic       rd_valid
);
  logic sel_ref;
  always_comb begin
    if (acr[5:3] == 3'b100)      sel_ref = (chip_id[0] == acr[2]);
    else if (acr[5:4] == 2'b11)  sel_ref = (chip_id == acr[3:2]);
    else                         sel_ref = 1'b1;
  end

  // R7
  bcast_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && acr[6] && (bus_addr <= 3'd2 || bus_addr == 3'd6) |=> !rd_valid);
  // R10
  read_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && !acr[6] |=> rd_valid);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !rd_valid);
  // R5
  auto_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && acr[7] |=> car == 8'($past(car) + 8'd1));
  // R5
  no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && !acr[7] |=> $stable(car));
  // R6
  hi_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> $stable(acr[1:0]));
  // R3
  we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> bus_sel && bus_wr && bus_addr == 3'd0);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R8
  bcast_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && acr[6] && !sel_ref && bus_addr != 3'd7 |-> !mem_we && !mem_re);
endmodule

bind hostport_indirect hostport_indirect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .acr(acr), .car(car),
  .mem_we(mem_we), .mem_re(mem_re), .rd_valid(rd_valid)
);

// File: tb/tb_hostport_indirect.sv
module tb_hostport_indirect;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  chip_id = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic        rd_valid, mem_we, mem_re;
  logic [7:0]  rd_data;
  logic [9:0]  mem_addr;
  logic [19:0] mem_wdata;

  hostport_indirect dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_acr = 0, m_car = 0, m_st2 = 0, m_st1 = 0, m_hold = 0;
  int m_sf[3] = '{0, 0, 0};
  int m_mem[int];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit hit(int instr, int id);
    if (instr == 8) return (id % 2) == 0;
    if (instr == 9) return (id % 2) == 1;
    if (instr >= 12) return id == instr - 12;
    return 1;
  endfunction

  task automatic acc(bit w, int a, int d, string req);
    bit bc, ok, e_we, e_re, e_v;
    int e_addr, e_wd, e_rd, word;
    bc = m_acr[6];
    ok = (a == 7) || !bc || hit((m_acr >> 2) & 15, chip_id);
    e_we = ok && w && a == 0;
    e_re = ok && !w && a == 0 && !bc;
    e_v = ok && !w && !(bc && (a <= 2 || a == 6));
    e_addr = ((m_acr & 3) << 8) | m_car;
    e_wd = (m_st2 << 16) | (m_st1 << 8) | d;
    e_rd = 0;
    @(negedge clk);
    bus_sel = 1; bus_wr = w; bus_addr = 3'(a); bus_wdata = 8'(d);
    #1;
    chk(mem_we == e_we, {req, " we"}, mem_we, e_we);
    chk(mem_re == e_re, {req, " re"}, mem_re, e_re);
    if (e_we) begin
      chk(mem_addr == 10'(e_addr), {req, " addr"}, mem_addr, e_addr);
      chk(mem_wdata == 20'(e_wd), {req, " wdata"}, mem_wdata, e_wd);
    end
    if (ok && w) begin
      case (a)
        7: m_acr = d;
        6: m_car = d;
        5, 4, 3: m_sf[a-3] = d;
        2: m_st2 = d & 15;
        1: m_st1 = d;
        default: begin
          m_mem[e_addr] = e_wd;
          if (m_acr[7]) m_car = (m_car + 1) % 256;
        end
      endcase
    end else if (e_v) begin
      case (a)
        7: e_rd = m_acr;
        6: e_rd = m_car;
        5, 4, 3: e_rd = m_sf[a-3];
        2: e_rd = (m_hold >> 8) & 15;
        1: e_rd = m_hold & 255;
        default: begin
          word = m_mem.exists(e_addr) ? m_mem[e_addr] : 0;
          e_rd = word & 255;
          m_hold = word >> 8;
          if (m_acr[7]) m_car = (m_car + 1) % 256;
        end
      endcase
    end
    @(posedge clk); #1;
    bus_sel = 0;
    chk(rd_valid == e_v, {req, " rd_valid"}, rd_valid, e_v);
    if (e_v) chk(rd_data == 8'(e_rd), {req, " rd_data"}, rd_data, e_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    chk(rd_valid == 0 && rd_data == 0, "R10 reset", {rd_valid, rd_data}, 0);
    chk(mem_we == 0 && mem_re == 0, "R10 reset strobes", {mem_we, mem_re}, 0);
    acc(0, 7, 0, "R10 ctl"); acc(0, 6, 0, "R10 ptr"); acc(0, 4, 0, "R10 sf");
    // R1 R2 R11
    acc(1, 7, 8'h3D & 8'hBF, "R1"); acc(0, 7, 0, "R1");
    acc(1, 7, 0, "R1");
    acc(1, 6, 8'h10, "R2"); acc(0, 6, 0, "R2");
    acc(1, 5, 8'hA1, "R11"); acc(1, 4, 8'hB2, "R11"); acc(1, 3, 8'hC3, "R11");
    acc(0, 5, 0, "R11"); acc(0, 4, 0, "R11"); acc(0, 3, 0, "R11");
    // R3 staging and commit
    acc(1, 2, 8'hF5, "R3"); acc(1, 1, 8'hAB, "R3"); acc(1, 0, 8'hCD, "R3");
    acc(0, 0, 0, "R4"); acc(0, 1, 0, "R4"); acc(0, 2, 0, "R4");
    // R4 coherence: overwrite after low-byte read
    acc(1, 2, 8'h01, "R4"); acc(1, 1, 8'h22, "R4"); acc(1, 0, 8'h33, "R4");
    acc(0, 1, 0, "R4 latched"); acc(0, 2, 0, "R4 latched");
    acc(0, 0, 0, "R4"); acc(0, 1, 0, "R4"); acc(0, 2, 0, "R4");
    // R5 R6 auto-increment across wrap, upper bits 10
    acc(1, 7, 8'h82, "R5"); acc(1, 6, 8'hFE, "R6");
    for (int i = 0; i < 3; i++) begin
      acc(1, 2, i + 7, "R5"); acc(1, 1, 8'h40 + i, "R5"); acc(1, 0, 8'h90 + i, "R6");
    end
    acc(0, 6, 0, "R6"); acc(0, 7, 0, "R6");
    acc(1, 6, 8'hFE, "R5");
    for (int i = 0; i < 3; i++) acc(0, 0, 0, "R6");
    acc(0, 6, 0, "R6");
    acc(1, 7, 8'h02, "R5"); acc(1, 6, 8'h00, "R5");
    acc(1, 0, 8'h55, "R5 no inc"); acc(0, 6, 0, "R5 no inc");
    // R7 R8 R9 R12 broadcast sweep
    for (int id = 0; id < 4; id++) begin
      for (int ins = 0; ins < 16; ins++) begin
        chip_id = 2'(id);
        acc(1, 7, 8'h03, "R9"); acc(1, 6, ins, "R9");
        acc(1, 1, 0, "R9"); acc(1, 2, 0, "R9"); acc(1, 0, 0, "R9");
        acc(1, 6, ins, "R9");
        acc(1, 7, 8'h43 | (ins << 2), "R8");
        acc(1, 1, 8'h60 + id, "R8"); acc(1, 0, 8'h80 + ins, "R8");
        acc(0, 0, 0, "R7"); acc(0, 6, 0, "R7"); acc(0, 1, 0, "R7");
        acc(0, 5, 0, "R8"); acc(0, 7, 0, "R8");
        acc(1, 7, 8'h03, "R12");
        acc(1, 6, ins, "R8"); acc(0, 0, 0, "R8"); acc(0, 1, 0, "R8");
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule